// File: doc/BRIEF.md
# Serial ADC readout controller

This block is the master end of a three-wire link to a successive-approximation converter. It drives an active-low chip select and a serial clock, and reads the converter's data line. Each start request opens one framed transfer. The block drops the two leading zero bits, gathers the result bits MSB first, and presents them as a parallel word with a one-cycle valid strobe.

A two-bit mode input picks the length of the frame. There is a full 16-clock frame and a 14-clock frame. There is also a short frame of two zeros plus the result width, which gives the highest throughput. The fourth length is an 8-clock burst, which the converter takes as a power-down command and which yields no sample. The serial clock comes from the system clock through an integer divider. After every frame, chip select stays high for a set quiet time before the block will accept another request.

Top module: `sar_serial_reader`

## Requirements
- R1: After reset, cs_n=1, sclk=1, busy=0 and valid=0.
- R2: sclk stays high whenever cs_n is high. Inside a frame, each sclk level lasts exactly HALF_DIV system clock cycles.
- R3: The mode code selects the number of sclk cycles in a frame: 0 gives 16, 1 gives 14, 2 gives RES_W+2 and 3 gives 8. cs_n rises on the last rising sclk edge of the frame.
- R4: sdata is sampled on every falling sclk edge. The first two samples are dropped. The next RES_W samples form the result, with the first one as the MSB.
- R5: Samples taken after the RES_W result bits (modes 0 and 1) are discarded and do not change the result.
- R6: valid is a single-cycle pulse in the system clock cycle after cs_n rises. It is high only while cs_n is high.
- R7: mode is captured when a request is accepted. Changes to mode during a frame do not change that frame's length.
- R8: busy goes high in the cycle after an accepted start. It stays high until QUIET_CYC cycles after cs_n rises. A start while busy is high opens no frame.
- R9: A mode-3 frame raises no valid and leaves sample holding its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one frame |
| mode | input | 2 | Frame kind: 0 full 16, 1 14-clock, 2 short, 3 power-down burst |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| busy | output | 1 | Frame or quiet time in progress |
| sample | output | RES_W | Last assembled result |
| valid | output | 1 | One-cycle strobe for a new sample |

## Verification
A wrong bit counter or a wrong frame-length decode shows up at the end of the first frame. The number of sclk falls, or the place where cs_n rises, is wrong, and so is the result: its bits are shifted or carry trailing ones. A fault in the divider changes the spacing of sclk edges in the first frame. A fault in the quiet counter or the busy logic shows up when busy falls early or late, or when a start issued during the quiet time pulls cs_n low.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  typedef enum logic [1:0] {
    FRM_LONG  = 2'd0,
    FRM_MID   = 2'd1,
    FRM_SHORT = 2'd2,
    FRM_SLEEP = 2'd3
  } frame_kind_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_RUN   = 2'd1,
    S_QUIET = 2'd2
  } seq_state_e;

  localparam int LONG_CLKS  = 16;
  localparam int MID_CLKS   = 14;
  localparam int SLEEP_CLKS = 8;
  localparam int LEAD_ZEROS = 2;
  localparam int EDGE_W     = 5;

endpackage

// File: rtl/sar_sclk_gen.sv
module sar_sclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic fall_stb,
  output logic rise_stb
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap     = run && (cnt == LAST);
  assign fall_stb = wrap && sclk;
  assign rise_stb = wrap && !sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b1;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: a toggle request is followed by the opposite level
  p_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    fall_stb |=> !sclk);

endmodule

// File: rtl/sar_frame_seq.sv
module sar_frame_seq
  import sar_rd_pkg::*;
#(
  parameter int RES_W     = 12,
  parameter int QUIET_CYC = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [1:0]  mode,
  input  logic        rise_stb,
  output logic        run,
  output logic        cs_n,
  output logic        busy,
  output logic        done,
  output logic        frame_start,
  output frame_kind_e kind_q
);
  localparam int QW = $clog2(QUIET_CYC + 1);
  localparam logic [QW-1:0] Q_LAST = QW'(QUIET_CYC - 1);

  seq_state_e         st;
  logic [EDGE_W-1:0]  rise_cnt;
  logic [EDGE_W-1:0]  len;
  logic [QW-1:0]      qcnt;

  always_comb begin
    case (kind_q)
      FRM_LONG:  len = EDGE_W'(LONG_CLKS);
      FRM_MID:   len = EDGE_W'(MID_CLKS);
      FRM_SHORT: len = EDGE_W'(RES_W + LEAD_ZEROS);
      default:   len = EDGE_W'(SLEEP_CLKS);
    endcase
  end

  assign run         = (st == S_RUN);
  assign frame_start = (st == S_IDLE) && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cs_n     <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
      rise_cnt <= '0;
      qcnt     <= '0;
      kind_q   <= FRM_LONG;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            kind_q   <= frame_kind_e'(mode);
            cs_n     <= 1'b0;
            busy     <= 1'b1;
            rise_cnt <= '0;
            st       <= S_RUN;
          end
        end
        S_RUN: begin
          if (rise_stb) begin
            if (rise_cnt == len - 1'b1) begin
              cs_n <= 1'b1;
              done <= 1'b1;
              qcnt <= '0;
              st   <= S_QUIET;
            end else begin
              rise_cnt <= rise_cnt + 1'b1;
            end
          end
        end
        S_QUIET: begin
          if (qcnt == Q_LAST) begin
            busy <= 1'b0;
            st   <= S_IDLE;
          end else begin
            qcnt <= qcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_edges_in_range_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_RUN) |-> (rise_cnt < len));

  p_cs_low_in_run_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_RUN) |-> !cs_n);

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    ((st == S_QUIET) && start) |=> cs_n);

  p_busy_covers_frame_r8: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);

  p_mode_held_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_RUN) |=> $stable(kind_q));

endmodule

// File: rtl/sar_sample_asm.sv
module sar_sample_asm
  import sar_rd_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             fall_stb,
  input  logic             sdata,
  input  logic             done,
  input  logic             keep,
  output logic [RES_W-1:0] sample,
  output logic             valid
);
  localparam logic [EDGE_W-1:0] FIRST = EDGE_W'(LEAD_ZEROS);
  localparam logic [EDGE_W-1:0] LIMIT = EDGE_W'(LEAD_ZEROS + RES_W);

  logic [EDGE_W-1:0] fall_cnt;
  logic [RES_W-1:0]  shreg;
  logic              in_window;

  assign in_window = (fall_cnt >= FIRST) && (fall_cnt < LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      fall_cnt <= '0;
      shreg    <= '0;
      sample   <= '0;
      valid    <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (clear) begin
        fall_cnt <= '0;
      end else if (fall_stb) begin
        fall_cnt <= fall_cnt + 1'b1;
        if (in_window) shreg <= {shreg[RES_W-2:0], sdata};
      end
      if (done && keep) begin
        sample <= shreg;
        valid  <= 1'b1;
      end
    end
  end

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  p_sleep_silent_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !keep) |=> (!valid && $stable(sample)));

endmodule

// File: rtl/sar_serial_reader.sv
module sar_serial_reader
  import sar_rd_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int RES_W     = 12,
  parameter int QUIET_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic             sdata,
  output logic             cs_n,
  output logic             sclk,
  output logic             busy,
  output logic [RES_W-1:0] sample,
  output logic             valid
);
  logic        run, fall_stb, rise_stb, done, frame_start;
  frame_kind_e kind_q;

  sar_sclk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst(rst), .run(run),
    .sclk(sclk), .fall_stb(fall_stb), .rise_stb(rise_stb)
  );

  sar_frame_seq #(.RES_W(RES_W), .QUIET_CYC(QUIET_CYC)) u_seq (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .rise_stb(rise_stb),
    .run(run), .cs_n(cs_n), .busy(busy), .done(done),
    .frame_start(frame_start), .kind_q(kind_q)
  );

  sar_sample_asm #(.RES_W(RES_W)) u_asm (
    .clk(clk), .rst(rst), .clear(frame_start), .fall_stb(fall_stb),
    .sdata(sdata), .done(done), .keep(kind_q != FRM_SLEEP),
    .sample(sample), .valid(valid)
  );

  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk);

  p_valid_after_cs_r6: assert property (@(posedge clk) disable iff (rst)
    valid |-> cs_n);

endmodule

// File: tb/test_sar_serial_reader.sv
`timescale 1ns/1ps
module test_sar_serial_reader;
  localparam int DIV = 2;
  localparam int W   = 8;
  localparam int Q   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic sdata;
  logic cs_n, sclk, busy, valid;
  logic [W-1:0] sample;

  always #4 clk = ~clk;

  sar_serial_reader #(.HALF_DIV(DIV), .RES_W(W), .QUIET_CYC(Q)) i_sar_serial_reader (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .sdata(sdata),
    .cs_n(cs_n), .sclk(sclk), .busy(busy), .sample(sample), .valid(valid)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // converter model: bit index advances on each rising sclk inside a frame
  logic [W-1:0] word_q = '0;
  int idx = 0;
  int falls = 0;
  int cs_falls = 0;
  int vcount = 0;
  int idle_bad = 0;
  int half_bad = 0;
  bit prev_ok = 0;
  time last_t = 0;

  always @(negedge cs_n) begin idx = 0; falls = 0; cs_falls++; prev_ok = 0; end
  always @(posedge cs_n) prev_ok = 0;
  always @(posedge sclk) if (!cs_n) idx++;
  always @(negedge sclk) falls++;
  always @(sclk) begin
    if (prev_ok && (($time - last_t) != time'(DIV * 8))) half_bad++;
    last_t = $time;
    prev_ok = !cs_n;
  end
  always @(negedge clk) begin
    if (!rst && cs_n && !sclk) idle_bad++;
    if (!rst && valid) vcount++;
  end

  assign sdata = (idx < 2) ? 1'b0 : (idx < 2 + W) ? word_q[W + 1 - idx] : 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic [1:0] m);
    case (m)
      2'd0: return 16;
      2'd1: return 14;
      2'd2: return W + 2;
      default: return 8;
    endcase
  endfunction

  logic [W-1:0] last_sample = '0;

  task automatic run_frame(input logic [1:0] m, input logic [W-1:0] w,
                           input bit chg_mode, input bit poke_busy);
    int v0, c0;
    word_q = w;
    while (busy) @(negedge clk);
    start = 1'b1;
    mode  = m;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && cs_n == 1'b0, "R8 busy/cs after start", {30'd0, busy, cs_n}, 2);
    if (chg_mode) mode = ~m;
    v0 = vcount;
    @(posedge cs_n);
    @(negedge clk);
    check(falls == len_of(m), chg_mode ? "R7 length kept after mode change" : "R3 frame length",
          falls, len_of(m));
    check(valid == 1'b0, "R6 no valid in cs rise cycle", int'(valid), 0);
    if (poke_busy) begin start = 1'b1; mode = 2'd0; end
    c0 = cs_falls;
    @(negedge clk);
    start = 1'b0;
    if (m != 2'd3) begin
      check(valid == 1'b1, "R6 valid pulse", int'(valid), 1);
      check(sample == w, (m == 2'd2) ? "R4 sample value" : "R5 trailing bits dropped",
            int'(sample), int'(w));
      last_sample = w;
    end else begin
      check(valid == 1'b0 && vcount == v0, "R9 no valid on sleep", vcount - v0, 0);
      check(sample == last_sample, "R9 sample kept", int'(sample), int'(last_sample));
    end
    for (int k = 0; k < Q - 2; k++) @(negedge clk);
    check(busy == 1'b1, "R8 busy through quiet", int'(busy), 1);
    @(negedge clk);
    check(busy == 1'b0, "R8 busy drop", int'(busy), 0);
    if (poke_busy) begin
      for (int k = 0; k < 4; k++) @(negedge clk);
      check(cs_falls == c0 && cs_n, "R8 start while busy ignored", cs_falls - c0, 0);
    end
    @(negedge clk);
    check(vcount - v0 == ((m != 2'd3) ? 1 : 0), "R6 single valid", vcount - v0,
          (m != 2'd3) ? 1 : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n == 1 && sclk == 1 && busy == 0 && valid == 0, "R1 reset state",
          {28'd0, cs_n, sclk, busy, valid}, 12);
    // short frames: every result value
    for (int v = 0; v < 256; v++) run_frame(2'd2, W'(v), 1'b0, 1'b0);
    // full frames with trailing bits
    for (int v = 0; v < 32; v++) run_frame(2'd0, W'(v * 8 + 3), 1'b0, 1'b0);
    for (int v = 0; v < 32; v++) run_frame(2'd1, W'(255 - v * 7), 1'b0, 1'b0);
    // power-down bursts leave the previous sample
    run_frame(2'd2, 8'hA5, 1'b0, 1'b0);
    for (int v = 0; v < 4; v++) run_frame(2'd3, W'(v * 60), 1'b0, 1'b0);
    // mode changes during a frame
    run_frame(2'd2, 8'h3C, 1'b1, 1'b0);
    run_frame(2'd0, 8'hC3, 1'b1, 1'b0);
    run_frame(2'd3, 8'h11, 1'b1, 1'b0);
    // start requests during the quiet time
    run_frame(2'd2, 8'h5A, 1'b0, 1'b1);
    run_frame(2'd1, 8'h81, 1'b0, 1'b1);
    check(half_bad == 0, "R2 half period", half_bad, 0);
    check(idle_bad == 0, "R2 sclk idle high", idle_bad, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule